// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a set of shared interrupt lines and delivers each one to the interrupt inputs of a small group of cores. Software sets it up through a single-cycle command port that carries an operation code, an interrupt index and a data word. For each shared line it keeps a core mask, a mode (fixed or rotating delivery, level or edge trigger) and a mask bit. A global enable gates all delivery.

The output is a flat vector with one request bit per core and per shared line. Core `c` receives line `i` on bit `c*NIRQ+i`. In fixed mode a line always goes to the lowest core in its mask. In rotating mode each new assertion goes to the next core in the mask after the one chosen last time, and the search wraps around. A level-triggered line keeps its chosen core until the line drops. An edge-triggered line gives a one-cycle pulse for each rising edge.

Top module: `shirq_dist`

## Requirements
- R1: After reset every output is 0, the global enable is off, every line is masked, every core mask is zero, every mode is fixed/level and every rotation pointer points to core 0.
- R2: Operation 1 sets the global enable from data bit 0. While the enable is off every output is 0, and no assertion seen then selects a core.
- R3: Operation 4 sets the line's mask bit from data bit 0 (1 = masked). A masked line drives no output, even while it is held active. Unmasking a line that is still held active and already has a core restores its output.
- R4: Operation 2 writes the line's core mask (data bits [NCORE-1:0], one bit per core). In fixed mode a line goes to exactly one core, the lowest set bit of the mask. The output appears after the clock edge that samples the input high.
- R5: Operation 3 writes the mode word: data bits [1:0] equal to 2'b00 select rotating delivery, and any other value selects fixed delivery. In rotating mode each new assertion picks the first core in the mask at or after the pointer, and the pointer then moves to the core after that one, wrapping around.
- R6: In level mode (mode data bit 4 = 1) the chosen core stays the same while the input is held, even if the core mask is rewritten in the meantime. The output follows the input low in the same cycle, and a new choice is made only after the input has been low.
- R7: A line whose core mask is all zero drives no core.
- R8: In edge mode (mode data bit 4 = 0) each rising edge of the input gives a pulse of exactly one cycle on the chosen core, and holding the input high gives no further pulses.
- R9: A command and an assertion in the same cycle: the choice made at that edge uses the enable, mask and core mask from before the command.
- R10: At any time each shared line drives at most one core output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation: 1 enable, 2 core mask, 3 mode, 4 mask |
| cmd_idx | input | $clog2(NIRQ) | Shared line addressed by the command |
| cmd_data | input | DW | Command data word |
| irq_in | input | NIRQ | Shared interrupt lines |
| core_irq | output | NCORE*NIRQ | Per-core requests, bit c*NIRQ+i |

## Verification
The case that needs the most care is a configuration command that lands in the same cycle as a new assertion on the line it reconfigures. Unmasking, enabling, disabling and rewriting the core mask are each driven in the cycle where the input rises. The bench then checks which core, if any, the selection at that edge chose, and compares it with the setting that held before the command. It also drives two lines that rise together in different modes and checks that each one lands on its own single core.

// File: rtl/shirq_dist.sv
module shirq_dist #(
  parameter int NCORE = 4,
  parameter int NIRQ  = 8,
  parameter int DW    = 8,
  localparam int IW   = $clog2(NIRQ),
  localparam int CW   = $clog2(NCORE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [IW-1:0]         cmd_idx,
  input  logic [DW-1:0]         cmd_data,
  input  logic [NIRQ-1:0]       irq_in,
  output logic [NCORE*NIRQ-1:0] core_irq
);
  localparam logic [2:0] OP_EN   = 3'd1;
  localparam logic [2:0] OP_DEST = 3'd2;
  localparam logic [2:0] OP_MODE = 3'd3;
  localparam logic [2:0] OP_MASK = 3'd4;

  logic en_q;
  logic [NIRQ-1:0] rr_q, lvl_q, mask_q, busy_q, pulse_q, prev_q, fire;

  function automatic logic [CW-1:0] first_from(input logic [NCORE-1:0] m, input logic [CW-1:0] start);
    logic [CW-1:0] r;
    logic found;
    r = start;
    found = 1'b0;
    for (int k = 0; k < NCORE; k++) begin
      int j;
      j = (int'(start) + k) % NCORE;
      if (!found && m[j]) begin
        r = CW'(j);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else if (cmd_valid && cmd_op == OP_EN) en_q <= cmd_data[0];

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    logic [NCORE-1:0] dest_q;
    logic [CW-1:0] ptr_q, sel_q, pick;
    logic hit;

    assign hit  = cmd_valid && cmd_idx == IW'(g);
    assign pick = first_from(dest_q, rr_q[g] ? ptr_q : '0);
    assign fire[g] = en_q & ~mask_q[g] & (|dest_q) & irq_in[g] &
                     (lvl_q[g] ? ~busy_q[g] : ~prev_q[g]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        dest_q <= '0;
        ptr_q <= '0;
        sel_q <= '0;
        rr_q[g] <= 1'b0;
        lvl_q[g] <= 1'b1;
        mask_q[g] <= 1'b1;
        busy_q[g] <= 1'b0;
        pulse_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= irq_in[g];
        pulse_q[g] <= fire[g] & ~lvl_q[g];
        if (fire[g]) begin
          sel_q <= pick;
          if (rr_q[g]) ptr_q <= (int'(pick) == NCORE-1) ? '0 : pick + 1'b1;
        end
        if (fire[g] && lvl_q[g]) busy_q[g] <= 1'b1;
        else if (!irq_in[g]) busy_q[g] <= 1'b0;
        if (hit && cmd_op == OP_DEST) dest_q <= cmd_data[NCORE-1:0];
        if (hit && cmd_op == OP_MODE) begin
          rr_q[g] <= cmd_data[1:0] == 2'b00;
          lvl_q[g] <= cmd_data[4];
        end
        if (hit && cmd_op == OP_MASK) mask_q[g] <= cmd_data[0];
      end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
      assign core_irq[c*NIRQ+g] = en_q & ~mask_q[g] & (sel_q == CW'(c)) &
                                  ((busy_q[g] & irq_in[g]) | pulse_q[g]);
    end
  end
endmodule

// File: rtl/shirq_dist_chk.sv
module shirq_dist_chk #(
  parameter int NCORE = 4,
  parameter int NIRQ  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_q,
  input logic [NIRQ-1:0]       mask_q,
  input logic [NIRQ-1:0]       lvl_q,
  input logic [NIRQ-1:0]       irq_in,
  input logic [NCORE*NIRQ-1:0] core_irq
);
  a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> core_irq == '0);

  for (genvar g = 0; g < NIRQ; g++) begin : g_ln
    logic [NCORE-1:0] col;
    for (genvar c = 0; c < NCORE; c++) begin : g_c
      assign col[c] = core_irq[c*NIRQ+g];
    end
    a_r10_single_core: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[g] |-> col == '0);
    a_r6_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[g] && !irq_in[g]) |-> col == '0);
  end
endmodule

bind shirq_dist shirq_dist_chk #(.NCORE(NCORE), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .mask_q(mask_q),
  .lvl_q(lvl_q), .irq_in(irq_in), .core_irq(core_irq)
);

// File: tb/shirq_dist_tb.sv
module shirq_dist_tb;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_idx = '0;
  logic [7:0] cmd_data = '0, irq_in = '0;
  logic [31:0] core_irq;
  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  shirq_dist u_dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in), .core_irq(core_irq));

  // {req, op, idx, data, irq, expected}
  localparam int NV = 49;
  localparam logic [57:0] VEC [NV] = '{
    {4'd1, 3'd0,3'd0,8'h00,8'h00,32'h0},          // R1 quiet
    {4'd4, 3'd2,3'd0,8'h06,8'h00,32'h0},
    {4'd4, 3'd3,3'd0,8'h11,8'h00,32'h0},
    {4'd3, 3'd4,3'd0,8'h00,8'h00,32'h0},
    {4'd2, 3'd0,3'd0,8'h00,8'h01,32'h0},          // R2 not enabled
    {4'd9, 3'd1,3'd0,8'h01,8'h01,32'h0},          // R9 enable same edge
    {4'd4, 3'd0,3'd0,8'h00,8'h01,32'h100},        // R4 lowest of 0110
    {4'd6, 3'd0,3'd0,8'h00,8'h01,32'h100},
    {4'd6, 3'd2,3'd0,8'h01,8'h01,32'h100},        // R6 held despite new mask
    {4'd6, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd6, 3'd0,3'd0,8'h00,8'h01,32'h1},
    {4'd3, 3'd4,3'd0,8'h01,8'h01,32'h0},          // R3 masked
    {4'd3, 3'd4,3'd0,8'h00,8'h01,32'h1},          // R3 unmasked
    {4'd6, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd5, 3'd2,3'd1,8'h0b,8'h00,32'h0},
    {4'd5, 3'd3,3'd1,8'h10,8'h00,32'h0},
    {4'd5, 3'd4,3'd1,8'h00,8'h00,32'h0},
    {4'd5, 3'd0,3'd0,8'h00,8'h02,32'h2},          // R5 core0
    {4'd5, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd5, 3'd0,3'd0,8'h00,8'h02,32'h200},        // R5 core1
    {4'd5, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd5, 3'd0,3'd0,8'h00,8'h02,32'h0200_0000},  // R5 skips core2
    {4'd5, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd5, 3'd0,3'd0,8'h00,8'h02,32'h2},          // R5 wrap
    {4'd5, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd7, 3'd3,3'd2,8'h11,8'h00,32'h0},
    {4'd7, 3'd4,3'd2,8'h00,8'h00,32'h0},
    {4'd7, 3'd0,3'd0,8'h00,8'h04,32'h0},          // R7 zero mask
    {4'd8, 3'd2,3'd3,8'h04,8'h00,32'h0},
    {4'd8, 3'd3,3'd3,8'h01,8'h00,32'h0},
    {4'd8, 3'd4,3'd3,8'h00,8'h00,32'h0},
    {4'd8, 3'd0,3'd0,8'h00,8'h08,32'h0008_0000},  // R8 pulse
    {4'd8, 3'd0,3'd0,8'h00,8'h08,32'h0},
    {4'd8, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd8, 3'd0,3'd0,8'h00,8'h08,32'h0008_0000},
    {4'd8, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd9, 3'd2,3'd4,8'h01,8'h00,32'h0},
    {4'd9, 3'd3,3'd4,8'h11,8'h00,32'h0},
    {4'd9, 3'd4,3'd4,8'h00,8'h10,32'h0},          // R9 unmask same edge
    {4'd9, 3'd0,3'd0,8'h00,8'h10,32'h10},
    {4'd9, 3'd2,3'd4,8'h02,8'h00,32'h0},
    {4'd9, 3'd2,3'd4,8'h08,8'h10,32'h1000},       // R9 old core mask used
    {4'd9, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd2, 3'd1,3'd0,8'h00,8'h10,32'h0},          // R2 disable
    {4'd2, 3'd0,3'd0,8'h00,8'h10,32'h0},
    {4'd2, 3'd0,3'd0,8'h00,8'h00,32'h0},
    {4'd2, 3'd1,3'd0,8'h01,8'h00,32'h0},
    {4'd10,3'd0,3'd0,8'h00,8'h03,32'h201},        // R10 two lines
    {4'd10,3'd0,3'd0,8'h00,8'h00,32'h0}
  };

  task automatic check(input logic [31:0] exp, input int req);
    nchk++;
    if (core_irq !== exp) begin
      nbad++;
      $display("FAIL R%0d: core_irq=%h expected %h", req, core_irq, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] d,
                       input logic [7:0] irq, input logic [31:0] exp, input int req);
    @(negedge clk);
    cmd_valid = (op != 3'd0);
    cmd_op = op; cmd_idx = idx; cmd_data = d; irq_in = irq;
    @(posedge clk);
    #2;
    check(exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(32'h0, 1);  // R1 during reset
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++)
      apply(VEC[v][53:51], VEC[v][50:48], VEC[v][47:40], VEC[v][39:32], VEC[v][31:0], int'(VEC[v][57:54]));
    @(negedge clk);
    rst_n = 1'b0; irq_in = 8'h01; cmd_valid = 1'b0;
    #1 check(32'h0, 1);  // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'd1, 3'd0, 8'h01, 8'h00, 32'h0, 1);
    apply(3'd4, 3'd0, 8'h00, 8'h01, 32'h0, 1);
    apply(3'd0, 3'd0, 8'h00, 8'h01, 32'h0, 1);  // R1 core mask cleared
    apply(3'd2, 3'd1, 8'h0b, 8'h00, 32'h0, 1);
    apply(3'd3, 3'd1, 8'h10, 8'h00, 32'h0, 1);
    apply(3'd4, 3'd1, 8'h00, 8'h00, 32'h0, 1);
    apply(3'd0, 3'd0, 8'h00, 8'h02, 32'h2, 1);  // R1 pointer cleared
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule